// File: doc/BRIEF.md
# Paged Indirect Register Window Bridge

This block lets a host reach a large internal register space through a small opening in its own register map. The host writes a page number into a page-select register. A later host access that lands in a 512-byte window is forwarded to an internal request/acknowledge bus. The internal address is the stored page joined with the low nine bits of the host address. Reads and writes both use the same window once the page is set.

The host side is a single-cycle register bus. A request is a one-cycle pulse on `host_req`, with `host_we` high for a write. Each accepted request is answered by a one-cycle pulse on `host_rvalid` (read) or `host_wdone` (write). Page-select accesses and accesses that decode to nothing are answered in the cycle after the request. A window access is answered in the cycle after the internal bus acknowledges. The internal side holds `ib_req` with a 32-bit address and data until `ib_ack`.

Top module: `page_window_bridge`

## Requirements
- R1: After reset the page register is zero, no response pulse and no internal request is active, and a window access goes to internal address {23'b0, offset}.
- R2: A host write to offset 0x41C stores `host_wdata[22:0]` as the page. A host read of 0x41C returns the page zero-extended to 32 bits. Both are answered in the following cycle.
- R3: A host access whose address bits [11:9] equal 3'b100 (0x800 to 0x9FF) raises `ib_req` in the next cycle. It carries `ib_addr` = {page, host_addr[8:0]}, `ib_we` = `host_we` and `ib_wdata` = `host_wdata`.
- R4: While `ib_req` is high and `ib_ack` is low, `ib_req`, `ib_addr`, `ib_we` and `ib_wdata` hold their values. `ib_req` drops in the cycle after `ib_ack` is sampled.
- R5: A window read is answered by one `host_rvalid` pulse in the cycle after the acknowledge, with `host_rdata` equal to `ib_rdata` as sampled with `ib_ack`.
- R6: A window write is answered by one `host_wdone` pulse in the cycle after the acknowledge.
- R7: A host access to any address that is neither 0x41C nor in the window is answered in the next cycle with read data zero. It is never forwarded to the internal bus, and it leaves the page unchanged.
- R8: A page write affects a window access issued in the very next cycle.
- R9: Host requests that arrive while a window access is outstanding are ignored. They produce no response and no change of the page.
- R10: `host_rvalid` and `host_wdone` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Read response pulse |
| host_wdone | output | 1 | Write completion pulse |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| ib_req | output | 1 | Internal request, held until acknowledged |
| ib_we | output | 1 | Internal write flag |
| ib_addr | output | 32 | Internal address {page, offset} |
| ib_wdata | output | 32 | Internal write data |
| ib_ack | input | 1 | Internal acknowledge |
| ib_rdata | input | 32 | Internal read data, valid with ib_ack |

## Verification
Two functions can meet in one cycle. A page-select write can be followed immediately by a window access, so the page update and the address build touch the same cycle. A host request can also arrive while a forwarded access is still waiting for its acknowledge. The bench provokes the first by issuing the window access in the same cycle that the page write's completion appears. The internal address that the bench's responder records must then carry the new page. The bench provokes the second by sending a page write during a slow acknowledge. Exactly one read response must come back, carrying the old page in its address, and a later readback of the page must still show the old value.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int PWB_HOST_AW   = 12;
    localparam int PWB_OFF_W     = 9;
    localparam int PWB_PAGE_W    = 23;
    localparam int PWB_DW        = 32;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PAGE = 2'd1,
        ACC_WIN  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/pwb_decode.sv
module pwb_decode
    import pwb_pkg::*;
#(
    parameter int               HOST_AW   = PWB_HOST_AW,
    parameter int               OFF_W     = PWB_OFF_W,
    parameter logic [HOST_AW-1:0] PAGE_ADDR = 12'h41C,
    parameter logic [HOST_AW-1:0] WIN_BASE  = 12'h800
) (
    input  logic [HOST_AW-1:0] addr,
    output acc_kind_e          kind
);
    localparam int TAG_W = HOST_AW - OFF_W;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[HOST_AW-1:OFF_W];

    always_comb begin
        if (addr[HOST_AW-1:OFF_W] == WIN_TAG)
            kind = ACC_WIN;
        else if (addr == PAGE_ADDR)
            kind = ACC_PAGE;
        else
            kind = ACC_NONE;
    end
endmodule

// File: rtl/pwb_ibus_master.sv
module pwb_ibus_master #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          ib_req,
    output logic          ib_we,
    output logic [AW-1:0] ib_addr,
    output logic [DW-1:0] ib_wdata,
    input  logic          ib_ack,
    input  logic [DW-1:0] ib_rdata,
    output logic          busy,
    output logic          done,
    output logic          done_we,
    output logic [DW-1:0] done_rdata
);
    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } ib_st_t;

    ib_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.req) begin
            if (start) begin
                st_d.req   = 1'b1;
                st_d.we    = start_we;
                st_d.addr  = start_addr;
                st_d.wdata = start_wdata;
            end
        end else if (ib_ack) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ib_req     = st_q.req;
    assign ib_we      = st_q.we;
    assign ib_addr    = st_q.addr;
    assign ib_wdata   = st_q.wdata;
    assign busy       = st_q.req;
    assign done       = st_q.req & ib_ack;
    assign done_we    = st_q.we;
    assign done_rdata = ib_rdata;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> !ib_req);
endmodule

// File: rtl/page_window_bridge.sv
module page_window_bridge
    import pwb_pkg::*;
#(
    parameter int HOST_AW = PWB_HOST_AW,
    parameter int OFF_W   = PWB_OFF_W,
    parameter int PAGE_W  = PWB_PAGE_W,
    parameter int DW      = PWB_DW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [HOST_AW-1:0]      host_addr,
    input  logic [DW-1:0]           host_wdata,
    output logic                    host_rvalid,
    output logic                    host_wdone,
    output logic [DW-1:0]           host_rdata,
    output logic                    ib_req,
    output logic                    ib_we,
    output logic [PAGE_W+OFF_W-1:0] ib_addr,
    output logic [DW-1:0]           ib_wdata,
    input  logic                    ib_ack,
    input  logic [DW-1:0]           ib_rdata
);
    localparam int IB_AW = PAGE_W + OFF_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              rvalid;
        logic              wdone;
        logic [DW-1:0]     rdata;
    } top_st_t;

    top_st_t   st_d, st_q;
    acc_kind_e kind;
    logic      busy, ib_done, ib_done_we, win_start;
    logic [DW-1:0] ib_done_rdata;

    pwb_decode #(.HOST_AW(HOST_AW), .OFF_W(OFF_W)) u_dec (
        .addr (host_addr),
        .kind (kind)
    );

    assign win_start = host_req && !busy && (kind == ACC_WIN);

    pwb_ibus_master #(.AW(IB_AW), .DW(DW)) u_ib (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (win_start),
        .start_we    (host_we),
        .start_addr  ({st_q.page, host_addr[OFF_W-1:0]}),
        .start_wdata (host_wdata),
        .ib_req      (ib_req),
        .ib_we       (ib_we),
        .ib_addr     (ib_addr),
        .ib_wdata    (ib_wdata),
        .ib_ack      (ib_ack),
        .ib_rdata    (ib_rdata),
        .busy        (busy),
        .done        (ib_done),
        .done_we     (ib_done_we),
        .done_rdata  (ib_done_rdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.wdone  = 1'b0;
        st_d.rdata  = '0;
        if (ib_done) begin
            if (ib_done_we) begin
                st_d.wdone = 1'b1;
            end else begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = ib_done_rdata;
            end
        end else if (host_req && !busy) begin
            unique case (kind)
                ACC_PAGE: begin
                    if (host_we) begin
                        st_d.page  = host_wdata[PAGE_W-1:0];
                        st_d.wdone = 1'b1;
                    end else begin
                        st_d.rvalid = 1'b1;
                        st_d.rdata  = {{(DW-PAGE_W){1'b0}}, st_q.page};
                    end
                end
                ACC_NONE: begin
                    st_d.wdone  = host_we;
                    st_d.rvalid = !host_we;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rvalid = st_q.rvalid;
    assign host_wdone  = st_q.wdone;
    assign host_rdata  = st_q.rdata;

    // R10
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_rvalid, host_wdone}));

    // R3
    fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ib_req) |-> $past(host_req && kind == ACC_WIN));

    // R5
    ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> (host_rvalid || host_wdone));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack && host_req) |=> !(host_rvalid || host_wdone));
endmodule

// File: tb/sim_page_window_bridge.sv
module sim_page_window_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rvalid, host_wdone;
    logic [31:0] host_rdata;
    logic        ib_req, ib_we;
    logic [31:0] ib_addr, ib_wdata;
    logic        ib_ack = 1'b0;
    logic [31:0] ib_rdata = '0;

    int checks = 0, failures = 0;
    int dly = 1;
    int req_count = 0, hold_err = 0;
    logic [31:0] rec_addr, rec_wdata, first_addr;
    logic        rec_we;
    bit          finished = 0;

    always #10 clk = ~clk;

    page_window_bridge u0 (
        .clk, .rst_n, .host_req, .host_we, .host_addr, .host_wdata,
        .host_rvalid, .host_wdone, .host_rdata,
        .ib_req, .ib_we, .ib_addr, .ib_wdata, .ib_ack, .ib_rdata
    );

    function automatic logic [31:0] rfun(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // internal bus responder
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (ib_ack) begin
                ib_ack = 1'b0;
                cnt = 0;
            end else if (ib_req) begin
                if (cnt == 0) begin
                    req_count++;
                    first_addr = ib_addr;
                end else if (ib_addr !== first_addr) begin
                    hold_err++;
                end
                cnt++;
                if (cnt >= dly) begin
                    ib_ack    = 1'b1;
                    ib_rdata  = rfun(ib_addr);
                    rec_addr  = ib_addr;
                    rec_we    = ib_we;
                    rec_wdata = ib_wdata;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic issue(input logic we, input logic [11:0] a, input logic [31:0] d);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic wait_resp(output logic rv, output logic wd, output logic [31:0] rd, output int n);
        n = 0;
        while (!(host_rvalid || host_wdone) && n < 60) begin
            @(negedge clk);
            n++;
        end
        rv = host_rvalid; wd = host_wdone; rd = host_rdata;
    endtask

    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int n);
        logic rv, wd;
        issue(we, a, d);
        wait_resp(rv, wd, rd, n);
        chk(we ? "R6 wdone" : "R5 rvalid", {31'b0, we ? wd : rv}, 32'd1);
        chk("R10 excl", {31'b0, rv & wd}, 32'd0);
    endtask

    initial begin
        logic [31:0] rd;
        int n, rc;
        logic rv, wd;
        logic [22:0] pages [5];
        pages[0] = 23'h000000; pages[1] = 23'h000001; pages[2] = 23'h2AAAAA;
        pages[3] = 23'h7FFFFF; pages[4] = 23'h155555;

        repeat (3) @(negedge clk);
        chk("R1 rvalid reset", {31'b0, host_rvalid}, 0);
        chk("R1 wdone reset", {31'b0, host_wdone}, 0);
        chk("R1 ib_req reset", {31'b0, ib_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        access(1'b0, 12'h41C, 0, rd, n);
        chk("R1 page reset", rd, 0);
        dly = 2;
        access(1'b0, 12'h81F, 0, rd, n);
        chk("R1 addr", rec_addr, 32'h1F);
        chk("R5 data", rd, rfun(32'h1F));

        // R2 masking of upper bits
        access(1'b1, 12'h41C, 32'hFFFF_FFFF, rd, n);
        chk("R2 wlat", n, 0);
        access(1'b0, 12'h41C, 0, rd, n);
        chk("R2 readback", rd, 32'h007F_FFFF);
        chk("R2 rlat", n, 0);

        // sweep pages x offsets, window access right after page write (R8)
        foreach (pages[p]) begin
            access(1'b1, 12'h41C, {9'h1A5, pages[p]}, rd, n);
            chk("R8 back to back", n, 0);
            for (int off = 0; off < 512; off += 7) begin
                logic [31:0] ea, wdv;
                ea  = {pages[p], off[8:0]};
                wdv = ea ^ 32'hC3C3_0F0F;
                dly = (off % 3) + 1;
                access(1'b0, 12'h800 | off[11:0], 0, rd, n);
                chk("R3 raddr", rec_addr, ea);
                chk("R3 rwe", {31'b0, rec_we}, 0);
                chk("R5 rdata", rd, rfun(ea));
                chk("R5 latency", n, dly);
                access(1'b1, 12'h800 | off[11:0], wdv, rd, n);
                chk("R3 waddr", rec_addr, ea);
                chk("R3 wwe", {31'b0, rec_we}, 1);
                chk("R3 wdata", rec_wdata, wdv);
                chk("R6 latency", n, dly);
            end
            dly = 1;
            access(1'b0, 12'h9FF, 0, rd, n);
            chk("R3 top offset", rec_addr, {pages[p], 9'h1FF});
            access(1'b0, 12'h41C, 0, rd, n);
            chk("R2 sweep readback", rd, {9'b0, pages[p]});
        end
        chk("R4 hold", hold_err, 0);

        // R7 outside addresses
        access(1'b1, 12'h41C, 32'h0000_1234, rd, n);
        rc = req_count;
        foreach (pages[k]) begin
            logic [11:0] oa;
            case (k)
                0: oa = 12'h418; 1: oa = 12'h420; 2: oa = 12'h7FC;
                3: oa = 12'hA00; default: oa = 12'hFFC;
            endcase
            access(1'b0, oa, 0, rd, n);
            chk("R7 zero", rd, 0);
            chk("R7 lat", n, 0);
            access(1'b1, oa, 32'hDEAD_BEEF, rd, n);
            chk("R7 wlat", n, 0);
        end
        @(negedge clk);
        chk("R7 no forward", req_count - rc, 0);
        access(1'b0, 12'h41C, 0, rd, n);
        chk("R7 page kept", rd, 32'h1234);

        // R9 request during outstanding access
        dly = 5;
        issue(1'b0, 12'h840, 0);
        issue(1'b1, 12'h41C, 32'h0000_0777);
        wait_resp(rv, wd, rd, n);
        chk("R9 only read resp", {30'b0, rv, wd}, 32'd2);
        chk("R9 old page addr", rec_addr, {23'h1234, 9'h040});
        @(negedge clk);
        chk("R9 single resp", {30'b0, host_rvalid, host_wdone}, 0);
        dly = 1;
        access(1'b0, 12'h41C, 0, rd, n);
        chk("R9 page unchanged", rd, 32'h1234);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule